// File: doc/BRIEF.md
# Regulator and PLL power-up sequencer

This block brings a display serial link wrapper out of power-down in a fixed order. A start pulse turns on the regulator and its bandgap reference together. The block then waits for the regulator to report ready, turns on the PLL, waits for the PLL to report lock, and finally enables the wrapper and raises `done`.

Each wait looks at its status input only at coarse polling instants. The microsecond time base comes from a prescaler of the system clock. A polling counter in microseconds sets the polling interval, and a poll counter limits how long a wait may last. If a wait runs out, the block records a warning flag for that stage and carries on to the next stage rather than stopping. Only a synchronous reset takes the block back to idle.

Top module: `pwr_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every enable, `done` and both timeout flags are 0. A `start` sampled high in idle sets `reg_en` in the next cycle.
- R2: `bgap_en` always equals `reg_en`, so the two rise in the same cycle.
- R3: A polling instant falls on the last cycle of every POLL_US*CLKS_PER_US cycles, counted from the first cycle of a wait. A status input counts as seen only if it is high in one of those cycles, so a pulse between polling instants is ignored.
- R4: `pll_en` rises k*POLL_US*CLKS_PER_US cycles after `reg_en` rises, where k is the first polling instant at which `reg_ready` is high. It never rises earlier.
- R5: If `reg_ready` is low at all NPOLL = ceil(LIMIT_US/POLL_US) polling instants, `reg_timeout` is set and `pll_en` rises at the last of those instants.
- R6: `link_en` and `done` rise together. The PLL wait follows the same timing as R4 and R5, using `pll_locked`, and sets `pll_timeout` when it runs out.
- R7: `start` has no effect once the sequence has left idle.
- R8: After an enable or flag is set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins the power-up sequence when idle |
| reg_ready | input | 1 | Regulator ready status |
| pll_locked | input | 1 | PLL lock status |
| reg_en | output | 1 | Regulator enable |
| bgap_en | output | 1 | Bandgap reference enable |
| pll_en | output | 1 | PLL enable |
| link_en | output | 1 | Wrapper enable |
| done | output | 1 | Sequence complete |
| reg_timeout | output | 1 | Regulator wait timed out (warning) |
| pll_timeout | output | 1 | PLL lock wait timed out (warning) |

## Verification
The assertions check the fixed relations on every cycle. The bandgap tracks the regulator enable. The enables follow their order and hold once set. `pll_en` rises only after `reg_ready` was sampled high or the regulator timeout flag was set. The regulator enable rises only after a start request.

The cycle-exact timing of each polling instant, the rejection of a pulse that falls between polls, and the cycle on which a timeout fires can only be shown by the bench. It sweeps the arrival time of each status input across the whole wait window and compares the measured stage lengths with values it computes itself.

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int CLKS_PER_US = 100,
  parameter int POLL_US     = 1000,
  parameter int LIMIT_US    = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic reg_ready,
  input  logic pll_locked,
  output logic reg_en,
  output logic bgap_en,
  output logic pll_en,
  output logic link_en,
  output logic done,
  output logic reg_timeout,
  output logic pll_timeout
);
  localparam int NPOLL = (LIMIT_US + POLL_US - 1) / POLL_US;
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam int QW = (POLL_US > 1) ? $clog2(POLL_US) : 1;
  localparam int NW = (NPOLL > 1) ? $clog2(NPOLL) : 1;

  typedef enum logic [1:0] {S_IDLE, S_REG, S_PLL, S_DONE} st_t;

  st_t           state;
  logic [PW-1:0] pre;
  logic [QW-1:0] poll;
  logic [NW-1:0] npoll;

  wire waiting   = (state == S_REG) || (state == S_PLL);
  wire us_tick   = waiting && (pre == PW'(CLKS_PER_US - 1));
  wire poll_hit  = us_tick && (poll == QW'(POLL_US - 1));
  wire last_poll = (npoll == NW'(NPOLL - 1));
  wire status    = (state == S_REG) ? reg_ready : pll_locked;
  wire advance   = poll_hit && (status || last_poll);

  assign reg_en  = (state != S_IDLE);
  assign bgap_en = reg_en;
  assign pll_en  = (state == S_PLL) || (state == S_DONE);
  assign link_en = (state == S_DONE);
  assign done    = link_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      pre         <= '0;
      poll        <= '0;
      npoll       <= '0;
      reg_timeout <= 1'b0;
      pll_timeout <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) state <= S_REG;
        S_REG, S_PLL: begin
          if (advance) begin
            pre   <= '0;
            poll  <= '0;
            npoll <= '0;
            if (state == S_REG) begin
              state <= S_PLL;
              if (!status) reg_timeout <= 1'b1;
            end else begin
              state <= S_DONE;
              if (!status) pll_timeout <= 1'b1;
            end
          end else begin
            pre <= us_tick ? '0 : pre + 1'b1;
            if (us_tick) poll <= poll_hit ? '0 : poll + 1'b1;
            if (poll_hit) npoll <= npoll + 1'b1;
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end
endmodule

module pwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic reg_ready,
  input logic reg_en,
  input logic bgap_en,
  input logic pll_en,
  input logic link_en,
  input logic done,
  input logic reg_timeout,
  input logic pll_timeout
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> !reg_en && !pll_en && !link_en && !reg_timeout && !pll_timeout);
  p_reg_needs_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_en) |-> $past(start));
  p_bgap_with_reg_r2: assert property (@(posedge clk) disable iff (rst)
    bgap_en == reg_en);
  p_pll_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en) |-> $past(reg_ready) || reg_timeout);
  p_pll_order_r4: assert property (@(posedge clk) disable iff (rst)
    pll_en |-> reg_en);
  p_flag_moves_on_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_timeout) |-> $rose(pll_en));
  p_link_order_r6: assert property (@(posedge clk) disable iff (rst)
    link_en |-> pll_en && done);
  p_hold_reg_r8: assert property (@(posedge clk) disable iff (rst)
    reg_en |=> reg_en);
  p_hold_link_r8: assert property (@(posedge clk) disable iff (rst)
    link_en |=> link_en && (pll_timeout == $past(pll_timeout)));
endmodule

bind pwr_seq pwr_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .reg_ready(reg_ready),
  .reg_en(reg_en), .bgap_en(bgap_en), .pll_en(pll_en), .link_en(link_en),
  .done(done), .reg_timeout(reg_timeout), .pll_timeout(pll_timeout)
);

// File: tb/sim_pwr_seq.sv
module sim_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 2;
  localparam int PUS = 3;
  localparam int LUS = 10;
  localparam int NPOLL = (LUS + PUS - 1) / PUS;
  localparam int P = CPU * PUS;

  logic clk = 0, rst = 1, start = 0, reg_ready = 0, pll_locked = 0;
  logic reg_en, bgap_en, pll_en, link_en, done, reg_timeout, pll_timeout;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq #(.CLKS_PER_US(CPU), .POLL_US(PUS), .LIMIT_US(LUS)) u0 (
    .clk(clk), .rst(rst), .start(start), .reg_ready(reg_ready),
    .pll_locked(pll_locked), .reg_en(reg_en), .bgap_en(bgap_en),
    .pll_en(pll_en), .link_en(link_en), .done(done),
    .reg_timeout(reg_timeout), .pll_timeout(pll_timeout));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int d, output bit tmo);
    for (int k = 1; k <= NPOLL; k++)
      if (k * P - 1 >= d) begin tmo = 0; return k * P; end
    tmo = 1;
    return NPOLL * P;
  endfunction

  task automatic run(input int dr, input int dp, input bit glitch);
    int n = 0, m = -1, reg_len = -1, pll_len = -1;
    bit bg_ok = 1, ord_ok = 1, hold_ok = 1;
    bit etr, etp;
    int el_r, el_p;
    rst = 1; start = 0; reg_ready = 0; pll_locked = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!reg_en && !bgap_en && !pll_en && !link_en && !done && !reg_timeout && !pll_timeout,
        "R1 reset state", {reg_en, pll_en, link_en, reg_timeout, pll_timeout}, 0);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(reg_en === 1'b1, "R1 start enables regulator", reg_en, 1);
    while (!done && n < 400) begin
      if (bgap_en !== reg_en) bg_ok = 0;
      if (!reg_en) hold_ok = 0;
      if (link_en && !pll_en) ord_ok = 0;
      if (pll_en && reg_len < 0) begin reg_len = n; m = 0; end
      reg_ready = glitch ? (n == 1) : (n >= dr);
      start = (n == 2 || n == P + 1);
      if (m >= 0) begin
        pll_locked = (m >= dp);
        m++;
      end
      @(negedge clk);
      n++;
    end
    start = 0;
    if (done) pll_len = m;
    el_r = exp_len(glitch ? 1000 : dr, etr);
    el_p = exp_len(dp, etp);
    chk(bg_ok, "R2 bandgap tracks regulator", bg_ok, 1);
    chk(reg_len == el_r, glitch ? "R3 glitch between polls ignored" : "R4 pll enable cycle", reg_len, el_r);
    chk(reg_timeout == etr, "R5 regulator timeout flag", reg_timeout, etr);
    chk(pll_len == el_p, "R6 wrapper enable cycle", pll_len, el_p);
    chk(pll_timeout == etp && link_en == done, "R6 pll timeout flag", pll_timeout, etp);
    chk(ord_ok && hold_ok, "R7 R8 start ignored, enables held", ord_ok && hold_ok, 1);
    repeat (3) @(negedge clk);
    chk(done && link_en && reg_en, "R8 done holds", done, 1);
  endtask

  initial begin
    for (int d = 0; d <= NPOLL * P + 1; d++) run(d, 0, 0);
    for (int d = 0; d <= NPOLL * P + 1; d++) run(0, d, 0);
    run(0, 3, 1);
    run(NPOLL * P + 5, NPOLL * P + 5, 0);
    rst = 1;
    @(negedge clk);
    chk(!reg_en && !pll_en && !link_en && !reg_timeout && !pll_timeout,
        "R1 mid-run reset clears", reg_timeout, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule